// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave that answers on a two-wire (I2C-style) bus the way a 512-byte serial EEPROM does. It runs on a system clock and oversamples the bus lines through synchronizers. Start and stop conditions and clock edges are then found from the synchronized levels. SDA is open-drain: the block only ever pulls it low, through `sda_pull_low_o`.

A master selects the device with an address byte made of a fixed type code, two select bits that must equal the `dev_sel_i` pins, the ninth word-address bit and a read/write flag. Writes go through a 16-byte page buffer, which is programmed into the internal array when the stop condition arrives. A busy counter then models the programming time. Reads come straight from the array. Byte write, page write, current-address read, random read (a dummy write followed by a repeated start) and sequential read are all supported. An internal word-address counter advances after every byte.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset every array location reads back as 0xFF.
- R2: The address byte is, MSB first, {4'b1010, sel[1:0], a8, rw}, with rw=1 meaning read. The slave pulls SDA low on the ninth clock only when the code is 1010 and sel equals `dev_sel_i`; otherwise SDA stays released.
- R3: In a write transfer the slave pulls SDA low during the ninth clock after the address byte, the word-address byte and every data byte.
- R4: The slave changes its SDA drive only after a falling SCL edge, or when a start or stop is seen. Each data bit it sends stays constant while SCL is high.
- R5: A single data byte written to a word address is held in the array after the stop and reads back unchanged.
- R6: Successive data bytes in one write transfer go to successive addresses whose low 4 bits wrap inside a 16-byte page while the upper bits stay fixed. All of them are programmed together at the stop.
- R7: Bit 1 of the address byte becomes bit 8 of the word address, so 0x1F3 and 0x0F3 are distinct locations.
- R8: A read started without a word address returns the byte one past the last byte read or written.
- R9: A random read (address byte with rw=0, word address, repeated start, address byte with rw=1) returns the byte at the given word address.
- R10: While the master acknowledges, a read keeps returning the following addresses. The address runs through the whole array and wraps from 0x1FF to 0x000.
- R11: When the master does not acknowledge a read byte, the slave releases SDA and ignores SCL until the next start.
- R12: For BUSY_CYCLES clock cycles after a stop that programs data, the slave does not acknowledge its address. Once that time has passed it acknowledges again.
- R13: Data bytes ended by a repeated start instead of a stop are discarded. They change no location and start no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| dev_sel_i | input | 2 | Select value the address byte bits 3:2 must match |
| sda_pull_low_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The hardest state to reach from the pins is the page buffer holding data when the transfer is broken off. Either a repeated start discards the data, or a stop programs it and the slave then refuses its address during the busy window. The bench gets there by issuing a data byte and then a repeated start with no stop, and by probing the address at once after a committing stop. It reads back to show that nothing, or exactly the wrapped page, reached the array. The 0x1FF to 0x000 rollover is reached by writing both end locations and then starting a random read at the top of the array.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } ee_state_t;

   typedef enum logic [1:0] {
      RX_DEVADDR,
      RX_WORDADDR,
      RX_DATA
   } ee_rx_t;
endpackage

// File: rtl/ee_line_sampler.sv
module ee_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_prev, sda_prev, scl_lvl;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin
                  scl_pipe[0] <= 1'b1;
                  sda_pipe[0] <= 1'b1;
               end else begin
                  scl_pipe[0] <= scl_i;
                  sda_pipe[0] <= sda_i;
               end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) begin
                  scl_pipe[g] <= 1'b1;
                  sda_pipe[g] <= 1'b1;
               end else begin
                  scl_pipe[g] <= scl_pipe[g-1];
                  sda_pipe[g] <= sda_pipe[g-1];
               end
         end
      end
   endgenerate

   assign scl_lvl = scl_pipe[SYNC_STAGES-1];
   assign sda_lvl = sda_pipe[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_lvl;
         sda_prev <= sda_lvl;
      end

   assign scl_rise  = scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl & scl_prev;
   assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/ee_store.sv
module ee_store #(
   parameter int MEM_BYTES   = 512,
   parameter int PAGE_BYTES  = 16,
   parameter int BUSY_CYCLES = 2000,
   localparam int ADDR_W = $clog2(MEM_BYTES),
   localparam int PAGE_W = $clog2(PAGE_BYTES),
   localparam int BASE_W = ADDR_W - PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_we,
   input  logic [PAGE_W-1:0] buf_slot,
   input  logic [7:0]        buf_din,
   input  logic              buf_clear,
   input  logic              commit,
   input  logic [BASE_W-1:0] commit_page,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy
);
   logic [7:0] mem [MEM_BYTES];
   logic [PAGE_BYTES-1:0][7:0] page_data;
   logic [PAGE_BYTES-1:0]      page_vld;

   generate
      for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
         logic [7:0] data_q;
         logic       vld_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               vld_q  <= 1'b0;
               data_q <= 8'hFF;
            end else if (buf_clear || commit) begin
               vld_q <= 1'b0;
            end else if (buf_we && buf_slot == PAGE_W'(s)) begin
               vld_q  <= 1'b1;
               data_q <= buf_din;
            end
         assign page_data[s] = data_q;
         assign page_vld[s]  = vld_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         for (int a = 0; a < MEM_BYTES; a++) mem[a] <= 8'hFF;
      end else if (commit) begin
         for (int s = 0; s < PAGE_BYTES; s++)
            if (page_vld[s]) mem[{commit_page, PAGE_W'(s)}] <= page_data[s];
      end

   assign rd_data = mem[rd_addr];

   generate
      if (BUSY_CYCLES == 0) begin : g_no_busy
         assign busy = 1'b0;
      end else begin : g_busy
         localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)          cnt_q <= '0;
            else if (commit)     cnt_q <= CNT_W'(BUSY_CYCLES);
            else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
         assign busy = (cnt_q != 0);

         assert_busy_after_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy) |-> $past(commit));
      end
   endgenerate

   assert_no_commit_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !busy);
endmodule

// File: rtl/ee_protocol.sv
module ee_protocol
   import eeprom_pkg::*;
#(
   parameter int         ADDR_W   = 9,
   parameter int         PAGE_W   = 4,
   parameter logic [3:0] DEV_CODE = 4'b1010,
   localparam int BASE_W = ADDR_W - PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [1:0]        dev_sel,
   input  logic              busy,
   input  logic [7:0]        rd_data,
   output logic              sda_drive,
   output logic              buf_we,
   output logic [PAGE_W-1:0] buf_slot,
   output logic [7:0]        buf_din,
   output logic              buf_clear,
   output logic              commit,
   output logic [BASE_W-1:0] commit_page,
   output logic [ADDR_W-1:0] rd_addr
);
   ee_state_t        state;
   ee_rx_t           kind;
   logic [3:0]       bitcnt;
   logic [7:0]       rx_sh;
   logic [6:0]       tx_sh;
   logic [ADDR_W-1:0] word_addr;
   logic             rd_mode, pending, mack;
   logic             addr_hit;

   assign addr_hit = (rx_sh[7:4] == DEV_CODE) && (rx_sh[3:2] == dev_sel) && !busy;
   assign rd_addr  = word_addr;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state       <= ST_IDLE;
         kind        <= RX_DEVADDR;
         bitcnt      <= '0;
         rx_sh       <= '0;
         tx_sh       <= '1;
         word_addr   <= '0;
         rd_mode     <= 1'b0;
         pending     <= 1'b0;
         mack        <= 1'b0;
         sda_drive   <= 1'b0;
         buf_we      <= 1'b0;
         buf_slot    <= '0;
         buf_din     <= '0;
         buf_clear   <= 1'b0;
         commit      <= 1'b0;
         commit_page <= '0;
      end else begin
         buf_we    <= 1'b0;
         buf_clear <= 1'b0;
         commit    <= 1'b0;
         if (start_det) begin
            state     <= ST_RX;
            kind      <= RX_DEVADDR;
            bitcnt    <= '0;
            sda_drive <= 1'b0;
            buf_clear <= 1'b1;
            pending   <= 1'b0;
         end else if (stop_det) begin
            state     <= ST_IDLE;
            sda_drive <= 1'b0;
            if (pending) begin
               commit      <= 1'b1;
               commit_page <= word_addr[ADDR_W-1:PAGE_W];
               pending     <= 1'b0;
            end
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise && bitcnt < 4'd8) begin
                     rx_sh  <= {rx_sh[6:0], sda_lvl};
                     bitcnt <= bitcnt + 1'b1;
                  end
                  if (scl_fall && bitcnt == 4'd8) begin
                     unique case (kind)
                        RX_DEVADDR: begin
                           if (addr_hit) begin
                              state                <= ST_ACK;
                              sda_drive            <= 1'b1;
                              rd_mode              <= rx_sh[0];
                              word_addr[ADDR_W-1]  <= rx_sh[1];
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        RX_WORDADDR: begin
                           word_addr[7:0] <= rx_sh;
                           state          <= ST_ACK;
                           sda_drive      <= 1'b1;
                        end
                        default: begin
                           buf_we                  <= 1'b1;
                           buf_slot                <= word_addr[PAGE_W-1:0];
                           buf_din                 <= rx_sh;
                           word_addr[PAGE_W-1:0]   <= word_addr[PAGE_W-1:0] + 1'b1;
                           pending                 <= 1'b1;
                           state                   <= ST_ACK;
                           sda_drive               <= 1'b1;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (kind == RX_DEVADDR && rd_mode) begin
                        state     <= ST_TX;
                        tx_sh     <= rd_data[6:0];
                        sda_drive <= ~rd_data[7];
                     end else begin
                        state     <= ST_RX;
                        sda_drive <= 1'b0;
                        kind      <= (kind == RX_DEVADDR) ? RX_WORDADDR : RX_DATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) bitcnt <= bitcnt + 1'b1;
                  if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        state     <= ST_MACK;
                        sda_drive <= 1'b0;
                        word_addr <= word_addr + 1'b1;
                     end else begin
                        sda_drive <= ~tx_sh[6];
                        tx_sh     <= {tx_sh[5:0], 1'b1};
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mack <= ~sda_lvl;
                  if (scl_fall) begin
                     if (mack) begin
                        state     <= ST_TX;
                        bitcnt    <= '0;
                        tx_sh     <= rd_data[6:0];
                        sda_drive <= ~rd_data[7];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end

   assert_drive_moves_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_drive != $past(sda_drive)) |-> $past(scl_fall || start_det || stop_det));

   assert_idle_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_drive);

   assert_ack_matches_address_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACK && kind == RX_DEVADDR) |->
         (rx_sh[7:4] == DEV_CODE && rx_sh[3:2] == dev_sel));

   assert_busy_refuses_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RX && kind == RX_DEVADDR && scl_fall && bitcnt == 4'd8 && busy)
         |=> (state == ST_IDLE && !sda_drive));

   assert_bit_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= 4'd8);
endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
   parameter int         MEM_BYTES   = 512,
   parameter int         PAGE_BYTES  = 16,
   parameter int         BUSY_CYCLES = 2000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_CODE    = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] dev_sel_i,
   output logic       sda_pull_low_o
);
   localparam int ADDR_W = $clog2(MEM_BYTES);
   localparam int PAGE_W = $clog2(PAGE_BYTES);
   localparam int BASE_W = ADDR_W - PAGE_W;

   generate
      if (ADDR_W != 9 || (1 << ADDR_W) != MEM_BYTES) begin : g_bad_mem
         $error("MEM_BYTES must be 512: one word-address byte plus one address-byte bit");
      end
      if (PAGE_BYTES < 2 || PAGE_BYTES > 256 || (1 << PAGE_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two between 2 and 256");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BUSY_CYCLES < 0) begin : g_bad_busy
         $error("BUSY_CYCLES must not be negative");
      end
   endgenerate

   logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic buf_we, buf_clear, commit, busy;
   logic [PAGE_W-1:0] buf_slot;
   logic [7:0]        buf_din, rd_data;
   logic [BASE_W-1:0] commit_page;
   logic [ADDR_W-1:0] rd_addr;

   ee_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   ee_protocol #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_CODE(DEV_CODE)) u_proto (
      .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .dev_sel(dev_sel_i), .busy(busy), .rd_data(rd_data),
      .sda_drive(sda_pull_low_o), .buf_we(buf_we), .buf_slot(buf_slot),
      .buf_din(buf_din), .buf_clear(buf_clear), .commit(commit),
      .commit_page(commit_page), .rd_addr(rd_addr)
   );

   ee_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_slot(buf_slot),
      .buf_din(buf_din), .buf_clear(buf_clear), .commit(commit),
      .commit_page(commit_page), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy)
   );
endmodule

// File: tb/tb_eeprom_2w_slave.sv
module tb_eeprom_2w_slave;
   localparam int Q    = 8;
   localparam int BUSY = 2000;

   logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
   logic [1:0] sel = 2'b10;
   logic drv;
   wire  sda_bus = sda_m & ~drv;

   always #10 clk = ~clk;

   eeprom_2w_slave #(.BUSY_CYCLES(BUSY)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .dev_sel_i(sel), .sda_pull_low_o(drv)
   );

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
   endtask

   task automatic get_bit(output logic v, output logic ok);
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); v = sda_bus; qw();
      ok = (sda_bus === v); scl_m = 1'b0; qw();
   endtask

   task automatic put_byte(input logic [7:0] b, output logic acked);
      logic v, ok;
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      get_bit(v, ok);
      acked = !v;
   endtask

   task automatic get_byte(output logic [7:0] d, input logic ack_it, output logic stable);
      logic v, ok;
      stable = 1'b1;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         get_bit(v, ok);
         d = {d[6:0], v};
         stable &= ok;
      end
      put_bit(!ack_it);
   endtask

   function automatic logic [7:0] devb(input logic a8, input logic rd);
      return {4'b1010, sel, a8, rd};
   endfunction

   task automatic write_bytes(input logic [8:0] a, input int n, input logic [7:0] d[4]);
      logic k;
      bus_start();
      put_byte(devb(a[8], 1'b0), k); chk("R3 address ack", k, 1);
      put_byte(a[7:0], k);           chk("R3 word address ack", k, 1);
      for (int i = 0; i < n; i++) begin
         put_byte(d[i], k);          chk("R3 data ack", k, 1);
      end
      bus_stop();
   endtask

   task automatic random_read(input logic [8:0] a, input int n, input logic [7:0] exp[8], input string req);
      logic k, st;
      logic [7:0] d;
      bus_start();
      put_byte(devb(a[8], 1'b0), k); chk("R9 dummy write ack", k, 1);
      put_byte(a[7:0], k);           chk("R9 word address ack", k, 1);
      bus_start();
      put_byte(devb(a[8], 1'b1), k); chk("R9 read address ack", k, 1);
      for (int i = 0; i < n; i++) begin
         get_byte(d, i < n - 1, st);
         chk(req, d, exp[i]);
         chk("R4 bit stable while SCL high", st, 1);
      end
      bus_stop();
   endtask

   task automatic wait_ready();
      repeat (BUSY + 100) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R11 SDA released after reset", drv, 0);
   endtask

   task automatic t_blank();
      logic [7:0] e[8] = '{default: 8'hFF};
      random_read(9'h000, 8, e, "R1 blank array reads FF (R10 sequential)");
   endtask

   task automatic t_byte_write();
      logic [7:0] d[4] = '{8'h5A, 8'h00, 8'h00, 8'h00};
      logic [7:0] e[8] = '{default: 8'hFF};
      write_bytes(9'h1F3, 1, d);
      wait_ready();
      e[0] = 8'h5A;
      random_read(9'h1F3, 1, e, "R5 byte write read back");
      e[0] = 8'hFF;
      random_read(9'h0F3, 1, e, "R7 bit 8 selects other half");
   endtask

   task automatic t_bad_address();
      logic k;
      bus_start();
      put_byte({4'b1011, sel, 1'b0, 1'b0}, k);
      chk("R2 wrong type code not acked", k, 0);
      bus_stop();
      bus_start();
      put_byte({4'b1010, ~sel, 1'b0, 1'b0}, k);
      chk("R2 wrong select bits not acked", k, 0);
      bus_stop();
   endtask

   task automatic t_page_write();
      logic [7:0] d[4] = '{8'h11, 8'h22, 8'h33, 8'h44};
      logic [7:0] e[8] = '{default: 8'hFF};
      write_bytes(9'h02E, 4, d);
      wait_ready();
      e[0] = 8'hFF; e[1] = 8'h11; e[2] = 8'h22; e[3] = 8'hFF;
      random_read(9'h02D, 4, e, "R6 page write, no spill to 0x030");
      e[0] = 8'h33; e[1] = 8'h44; e[2] = 8'hFF;
      random_read(9'h020, 3, e, "R6 page write wraps to page start");
   endtask

   task automatic t_busy();
      logic [7:0] d[4] = '{8'hA5, 8'h00, 8'h00, 8'h00};
      logic k;
      write_bytes(9'h040, 1, d);
      bus_start();
      put_byte(devb(1'b0, 1'b0), k);
      chk("R12 address refused while busy", k, 0);
      bus_stop();
      wait_ready();
      bus_start();
      put_byte(devb(1'b0, 1'b0), k);
      chk("R12 address acked after busy", k, 1);
      bus_stop();
   endtask

   task automatic t_current_read();
      logic [7:0] e[8] = '{default: 8'hFF};
      logic [7:0] d;
      logic k, st, v, ok;
      e[0] = 8'h11;
      random_read(9'h02E, 1, e, "R9 random read");
      bus_start();
      put_byte(devb(1'b0, 1'b1), k);
      chk("R8 current read address ack", k, 1);
      get_byte(d, 1'b0, st);
      chk("R8 current read returns next byte", d, 8'h22);
      get_bit(v, ok);
      chk("R11 SDA released after master NACK", v, 1);
      bus_stop();
   endtask

   task automatic t_wrap();
      logic [7:0] d[4] = '{8'hC3, 8'h00, 8'h00, 8'h00};
      logic [7:0] e[8] = '{default: 8'hFF};
      write_bytes(9'h1FF, 1, d);
      wait_ready();
      d[0] = 8'h3C;
      write_bytes(9'h000, 1, d);
      wait_ready();
      e[0] = 8'hC3; e[1] = 8'h3C;
      random_read(9'h1FF, 2, e, "R10 sequential read wraps 0x1FF to 0x000");
   endtask

   task automatic t_restart_discard();
      logic [7:0] e[8] = '{default: 8'hFF};
      logic [7:0] d;
      logic k, st;
      bus_start();
      put_byte(devb(1'b0, 1'b0), k);
      put_byte(8'h50, k);
      put_byte(8'h77, k);
      chk("R3 data ack before restart", k, 1);
      bus_start();
      put_byte(devb(1'b0, 1'b1), k);
      get_byte(d, 1'b0, st);
      chk("R13 restart read sees 0x051 blank", d, 8'hFF);
      bus_stop();
      random_read(9'h050, 1, e, "R13 discarded byte not written");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_blank();
      t_byte_write();
      t_bad_address();
      t_page_write();
      t_busy();
      t_current_read();
      t_wrap();
      t_restart_discard();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule